// File: doc/BRIEF.md
# Standby Entry and Wake Sequencer

This block decides when a small microcontroller drops into deep standby and how it comes back out. A sleep strobe from the CPU puts the part into standby only while the standby-select control bit is set. In standby the oscillator enable and the chip clock enable are both low. The address and bus-control pin output enables either keep driving or drop to high impedance, according to a control bit captured at entry.

Wake sources are a non-maskable interrupt, eight external interrupt lines, the active-low reset pin and an active-low hardware-standby pin. Each of these passes through a two-flop synchronizer. An interrupt wake restarts the oscillator first and holds the chip clocks off for a programmable settling time. Clocks then return together with a one-cycle exception request that carries a source code. A reset-pin wake turns every clock on at once and raises a reset request when the pin is released. The hardware-standby pin overrides everything else.

The block runs on an always-on reference clock, so its settling counter keeps counting while the main oscillator is stopped. All of its pins are plain control and status signals; it has no streaming interface.

Top module: `stby_seq`

## Requirements
- R1: In the run state, a sleep strobe with `stby_sel`=1 enters standby on that clock edge. A sleep strobe with `stby_sel`=0 has no effect, and `osc_en` and `clk_en` stay 1.
- R2: In standby, `osc_en`=0 and `clk_en`=0, and no exception request is issued while no wake source is valid.
- R3: During standby and settling, `bus_oe` equals the `bus_keep` value sampled on the entry edge (1 = keep driving, 0 = high impedance). In hardware standby, `bus_oe`=0.
- R4: Interrupt line i wakes the block only when `irq_en[i]`=1, `cpu_irq_mask`=0 and `irq_dma_route[i]`=0. The NMI input wakes the block regardless of these bits.
- R5: Lines 3 to 7 additionally need `irq_qual`=1. Lines 0 to 2 ignore `irq_qual`.
- R6: On an interrupt wake, `osc_en` rises first. `clk_en` stays 0 for exactly 2^(SETTLE_BASE+n) cycles, where n is the `settle_sel` value captured at entry. `clk_en` and the exception request then appear together.
- R7: When the synchronized reset pin is low in standby, `osc_en` and `clk_en` both go to 1 without any settling wait. When the pin returns high, a reset request with code 0 is issued.
- R8: When the synchronized hardware-standby pin is low, the block enters hardware standby from any state (`hw_stby`=1, `osc_en`=0, `clk_en`=0). Releasing the pin passes through the reset path of R7.
- R9: Wake priority, highest first: hardware-standby pin, reset pin, NMI, then interrupt lines with the lowest index winning.
- R10: `exc_req` is a single-cycle pulse. `exc_code` is 0 for reset, 1 for NMI, and 2+i for interrupt line i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| sleep_stb | input | 1 | Sleep-instruction retire strobe |
| stby_sel | input | 1 | Standby-select control bit |
| bus_keep | input | 1 | 1 = bus pins keep driving in standby |
| settle_sel | input | 3 | Settling-time selector n |
| irq_en | input | 8 | Per-line interrupt enables |
| irq_qual | input | 1 | Qualifier for lines 3..7 |
| cpu_irq_mask | input | 1 | CPU-side interrupt mask |
| irq_dma_route | input | 8 | Line routed to DMA-transfer activation |
| nmi_in | input | 1 | Non-maskable interrupt, active high |
| irq_in | input | 8 | External interrupt lines, active high |
| rst_pin_n | input | 1 | Reset pin, active low |
| hstby_pin_n | input | 1 | Hardware-standby pin, active low |
| osc_en | output | 1 | Main oscillator enable |
| clk_en | output | 1 | Chip clock enable |
| bus_oe | output | 1 | Address/bus-control pin output enable |
| hw_stby | output | 1 | Hardware standby active |
| exc_req | output | 1 | Exception request pulse |
| exc_code | output | 4 | Exception source code |

## Verification
A stuck or wrong state register shows up at the ports within one cycle as a wrong combination of `osc_en`, `clk_en` and `bus_oe`. For example, clocks enabled while the oscillator is off, or bus drive that does not match the captured control bit. A wrong wake decision shows up as a wrong `exc_code`, or as no pulse at all. Settling-counter faults appear only at the end of the wait, as a `clk_en` rise one or more cycles away from the expected power of two. The bench therefore measures that interval exactly for every chosen n.

// File: rtl/stby_pkg.sv
package stby_pkg;
  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_STBY    = 3'd1,
    ST_SETTLE  = 3'd2,
    ST_RSTHOLD = 3'd3,
    ST_HWSTBY  = 3'd4
  } pwr_state_t;

  localparam int CODE_W = 4;
  localparam logic [CODE_W-1:0] CODE_RESET = 4'd0;
  localparam logic [CODE_W-1:0] CODE_NMI   = 4'd1;
  localparam logic [CODE_W-1:0] CODE_IRQ0  = 4'd2;
endpackage

// File: rtl/stby_sync.sv
module stby_sync #(
  parameter int W = 1,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      meta <= {W{RST_VAL}};
      q    <= {W{RST_VAL}};
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/stby_wake_pick.sv
module stby_wake_pick
  import stby_pkg::*;
#(
  parameter int IRQ_N   = 8,
  parameter int QUAL_LO = 3
) (
  input  logic              nmi,
  input  logic [IRQ_N-1:0]  irq_lvl,
  input  logic [IRQ_N-1:0]  irq_en,
  input  logic              irq_qual,
  input  logic              cpu_irq_mask,
  input  logic [IRQ_N-1:0]  irq_dma_route,
  output logic              wake,
  output logic [CODE_W-1:0] code
);
  logic [IRQ_N-1:0] line_ok;

  // Per-line qualification; upper lines also need the qualifier bit.
  for (genvar i = 0; i < IRQ_N; i++) begin : g_line
    if (i >= QUAL_LO) begin : g_hi
      assign line_ok[i] = irq_lvl[i] & irq_en[i] & ~irq_dma_route[i] & ~cpu_irq_mask & irq_qual;
    end else begin : g_lo
      assign line_ok[i] = irq_lvl[i] & irq_en[i] & ~irq_dma_route[i] & ~cpu_irq_mask;
    end
  end

  always_comb begin
    wake = 1'b0;
    code = CODE_NMI;
    // Walk from high to low index so the lowest valid line is kept.
    for (int i = IRQ_N - 1; i >= 0; i--) begin
      if (line_ok[i]) begin
        wake = 1'b1;
        code = CODE_IRQ0 + CODE_W'(i);
      end
    end
    if (nmi) begin
      wake = 1'b1;
      code = CODE_NMI;
    end
  end
endmodule

// File: rtl/stby_settle_ctr.sv
module stby_settle_ctr #(
  parameter int SETTLE_BASE = 13,
  parameter int SEL_W       = 3
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             done
);
  localparam int CNT_W = SETTLE_BASE + (1 << SEL_W) - 1;
  localparam logic [SEL_W-1:0] SEL_MAX = '1;
  localparam logic [CNT_W-1:0] ALL1 = '1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  // Last count value is 2^(SETTLE_BASE+sel) - 1.
  assign last = ALL1 >> (SEL_MAX - sel);
  assign done = run && (cnt == last);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          cnt <= '0;
    else if (!run || done) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/stby_seq.sv
module stby_seq
  import stby_pkg::*;
#(
  parameter int IRQ_N       = 8,
  parameter int QUAL_LO     = 3,
  parameter int SETTLE_BASE = 13,
  parameter int SEL_W       = 3
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sleep_stb,
  input  logic              stby_sel,
  input  logic              bus_keep,
  input  logic [SEL_W-1:0]  settle_sel,
  input  logic [IRQ_N-1:0]  irq_en,
  input  logic              irq_qual,
  input  logic              cpu_irq_mask,
  input  logic [IRQ_N-1:0]  irq_dma_route,
  input  logic              nmi_in,
  input  logic [IRQ_N-1:0]  irq_in,
  input  logic              rst_pin_n,
  input  logic              hstby_pin_n,
  output logic              osc_en,
  output logic              clk_en,
  output logic              bus_oe,
  output logic              hw_stby,
  output logic              exc_req,
  output logic [CODE_W-1:0] exc_code
);
  pwr_state_t        state, nxt;
  logic              nmi_s, rst_s, hst_s;
  logic [IRQ_N-1:0]  irq_s;
  logic              wake;
  logic [CODE_W-1:0] wake_code;
  logic              settle_done;
  logic              keep_q;
  logic [SEL_W-1:0]  sel_q;
  logic [CODE_W-1:0] pend_q;
  logic              fire;
  logic [CODE_W-1:0] fire_code;

  stby_sync #(.W(IRQ_N + 1), .RST_VAL(1'b0)) u_sync_int (
    .clk(clk), .por_n(por_n), .d({nmi_in, irq_in}), .q({nmi_s, irq_s})
  );
  stby_sync #(.W(2), .RST_VAL(1'b1)) u_sync_pin (
    .clk(clk), .por_n(por_n), .d({rst_pin_n, hstby_pin_n}), .q({rst_s, hst_s})
  );

  stby_wake_pick #(.IRQ_N(IRQ_N), .QUAL_LO(QUAL_LO)) u_pick (
    .nmi(nmi_s), .irq_lvl(irq_s), .irq_en(irq_en), .irq_qual(irq_qual),
    .cpu_irq_mask(cpu_irq_mask), .irq_dma_route(irq_dma_route),
    .wake(wake), .code(wake_code)
  );

  stby_settle_ctr #(.SETTLE_BASE(SETTLE_BASE), .SEL_W(SEL_W)) u_settle (
    .clk(clk), .por_n(por_n), .run(state == ST_SETTLE), .sel(sel_q),
    .done(settle_done)
  );

  always_comb begin
    nxt       = state;
    fire      = 1'b0;
    fire_code = CODE_RESET;
    if (!hst_s) begin
      nxt = ST_HWSTBY;
    end else if (state == ST_HWSTBY || !rst_s) begin
      nxt = ST_RSTHOLD;
    end else begin
      unique case (state)
        ST_RUN:     if (sleep_stb && stby_sel) nxt = ST_STBY;
        ST_STBY:    if (wake) nxt = ST_SETTLE;
        ST_SETTLE:  if (settle_done) begin
                      nxt       = ST_RUN;
                      fire      = 1'b1;
                      fire_code = pend_q;
                    end
        ST_RSTHOLD: begin
                      nxt  = ST_RUN;
                      fire = 1'b1;
                    end
        default:    nxt = ST_RSTHOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state    <= ST_RUN;
      keep_q   <= 1'b1;
      sel_q    <= '0;
      pend_q   <= CODE_NMI;
      exc_req  <= 1'b0;
      exc_code <= CODE_RESET;
    end else begin
      state   <= nxt;
      exc_req <= fire;
      if (fire) exc_code <= fire_code;
      if (state == ST_RUN && nxt == ST_STBY) begin
        keep_q <= bus_keep;
        sel_q  <= settle_sel;
      end
      if (state == ST_STBY && nxt == ST_SETTLE) pend_q <= wake_code;
    end
  end

  assign osc_en  = (state != ST_STBY) && (state != ST_HWSTBY);
  assign clk_en  = (state == ST_RUN) || (state == ST_RSTHOLD);
  assign hw_stby = (state == ST_HWSTBY);
  assign bus_oe  = (state == ST_STBY || state == ST_SETTLE) ? keep_q
                 : (state != ST_HWSTBY);
endmodule

// File: rtl/stby_seq_chk.sv
module stby_seq_chk
  import stby_pkg::*;
(
  input logic              clk,
  input logic              por_n,
  input logic              sleep_stb,
  input logic              stby_sel,
  input logic              bus_keep,
  input logic              rst_s,
  input logic              hst_s,
  input pwr_state_t        state,
  input logic              osc_en,
  input logic              clk_en,
  input logic              bus_oe,
  input logic              hw_stby,
  input logic              exc_req,
  input logic [CODE_W-1:0] exc_code
);
  p_sel_gate_r1: assert property (@(posedge clk) disable iff (!por_n)
    (state == ST_RUN && sleep_stb && !stby_sel && hst_s) |=> (osc_en && clk_en));

  p_enter_off_r2: assert property (@(posedge clk) disable iff (!por_n)
    (state == ST_RUN && sleep_stb && stby_sel && hst_s && rst_s) |=> (!osc_en && !clk_en));

  p_bus_keep_r3: assert property (@(posedge clk) disable iff (!por_n)
    ($fell(clk_en) && !hw_stby) |-> (bus_oe == $past(bus_keep)));

  p_settle_gate_r6: assert property (@(posedge clk) disable iff (!por_n)
    (state == ST_SETTLE) |-> (osc_en && !clk_en));

  p_clk_needs_osc_r6: assert property (@(posedge clk) disable iff (!por_n)
    clk_en |-> osc_en);

  p_rst_fast_r7: assert property (@(posedge clk) disable iff (!por_n)
    (state == ST_RSTHOLD) |-> (osc_en && clk_en));

  p_hw_enter_r8: assert property (@(posedge clk) disable iff (!por_n)
    !hst_s |=> (hw_stby && !osc_en && !bus_oe));

  p_pulse_r10: assert property (@(posedge clk) disable iff (!por_n)
    exc_req |=> !exc_req);

  p_code_r10: assert property (@(posedge clk) disable iff (!por_n)
    exc_req |-> (exc_code <= 4'd9 && clk_en));
endmodule

bind stby_seq stby_seq_chk u_chk (
  .clk(clk), .por_n(por_n), .sleep_stb(sleep_stb), .stby_sel(stby_sel),
  .bus_keep(bus_keep), .rst_s(rst_s), .hst_s(hst_s), .state(state),
  .osc_en(osc_en), .clk_en(clk_en), .bus_oe(bus_oe), .hw_stby(hw_stby),
  .exc_req(exc_req), .exc_code(exc_code)
);

// File: tb/stby_seq_test.sv
`timescale 1ns/1ps
module stby_seq_test;
  localparam int SB = 3;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic sleep_stb = 0, stby_sel = 0, bus_keep = 0, irq_qual = 0, cpu_irq_mask = 0;
  logic [2:0] settle_sel = 0;
  logic [7:0] irq_en = 0, irq_dma_route = 0, irq_in = 0;
  logic nmi_in = 0, rst_pin_n = 1, hstby_pin_n = 1;
  logic osc_en, clk_en, bus_oe, hw_stby, exc_req;
  logic [3:0] exc_code;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  stby_seq #(.SETTLE_BASE(SB)) uut (
    .clk(clk), .por_n(por_n), .sleep_stb(sleep_stb), .stby_sel(stby_sel),
    .bus_keep(bus_keep), .settle_sel(settle_sel), .irq_en(irq_en),
    .irq_qual(irq_qual), .cpu_irq_mask(cpu_irq_mask), .irq_dma_route(irq_dma_route),
    .nmi_in(nmi_in), .irq_in(irq_in), .rst_pin_n(rst_pin_n), .hstby_pin_n(hstby_pin_n),
    .osc_en(osc_en), .clk_en(clk_en), .bus_oe(bus_oe), .hw_stby(hw_stby),
    .exc_req(exc_req), .exc_code(exc_code)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_code(bit nmi, logic [7:0] irq, logic [7:0] en,
                                  bit qual, bit mask, logic [7:0] route);
    if (nmi) return 1;
    for (int i = 0; i < 8; i++)
      if (irq[i] && en[i] && !mask && !route[i] && (i < 3 || qual)) return 2 + i;
    return -1;
  endfunction

  task automatic enter(bit keep, int n);
    stby_sel = 1; bus_keep = keep; settle_sel = 3'(n); sleep_stb = 1;
    tick(1);
    sleep_stb = 0; bus_keep = ~keep;
    chk(!osc_en && !clk_en, "R2 standby clocks", {osc_en, clk_en}, 0);
    chk(bus_oe == keep, "R3 bus_oe", bus_oe, keep);
  endtask

  task automatic wait_exc(output int code, output int settle, output bit got);
    code = -1; settle = 0; got = 0;
    for (int k = 0; k < 3000 && !got; k++) begin
      tick(1);
      if (osc_en && !clk_en) settle++;
      if (exc_req) begin
        got = 1; code = exc_code;
        chk(clk_en, "R6 clk_en with request", clk_en, 1);
      end
    end
    tick(1);
    chk(!exc_req, "R10 single pulse", exc_req, 0);
  endtask

  initial begin
    #(20 * 190000);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int code, settle, e;
    bit got;
    logic [7:0] irq;
    bit nmi;
    void'($urandom(32'h5eed_1234));
    tick(3);
    por_n = 1;
    tick(4);
    chk(osc_en && clk_en && bus_oe && !hw_stby && !exc_req, "R2 reset state",
        {osc_en, clk_en, bus_oe, hw_stby, exc_req}, 5'b11100);

    // R1: sleep strobe without the select bit
    stby_sel = 0; sleep_stb = 1; tick(1); sleep_stb = 0; tick(2);
    chk(osc_en && clk_en, "R1 no entry with sel=0", {osc_en, clk_en}, 3);

    // R2: stays in standby with no wake source, bus high-Z variant
    enter(0, 0);
    tick(30);
    chk(!osc_en && !clk_en && !exc_req, "R2 idle standby", {osc_en, clk_en}, 0);
    irq_en = 8'hFF; irq_in = 8'h01;
    wait_exc(code, settle, got);
    chk(code == 2, "R4 irq0 code", code, 2);
    chk(settle == (1 << SB), "R6 settle n=0", settle, 1 << SB);
    irq_in = 0; tick(3);

    // R5: line 5 blocked without qualifier, accepted with it
    enter(1, 2);
    irq_qual = 0; irq_in = 8'h20; tick(20);
    chk(!osc_en, "R5 line5 needs qual", osc_en, 0);
    irq_qual = 1;
    wait_exc(code, settle, got);
    chk(code == 7, "R5 line5 code", code, 7);
    chk(settle == (1 << (SB + 2)), "R6 settle n=2", settle, 1 << (SB + 2));
    irq_in = 0; tick(3);

    // R9: two irq lines together, lowest wins; then NMI beats irq
    enter(1, 1);
    irq_in = 8'h24;
    wait_exc(code, settle, got);
    chk(code == 4, "R9 lowest irq wins", code, 4);
    irq_in = 0; tick(3);
    enter(0, 0);
    irq_in = 8'h01; nmi_in = 1;
    wait_exc(code, settle, got);
    chk(code == 1, "R9 nmi over irq", code, 1);
    irq_in = 0; nmi_in = 0; tick(3);

    // R7 / R9: reset pin together with NMI, no settle wait
    enter(1, 7);
    rst_pin_n = 0; nmi_in = 1; tick(4);
    chk(osc_en && clk_en, "R7 clocks at once", {osc_en, clk_en}, 3);
    tick(4);
    chk(!exc_req, "R7 no request while held", exc_req, 0);
    nmi_in = 0; rst_pin_n = 1;
    wait_exc(code, settle, got);
    chk(got && code == 0, "R7 reset code", code, 0);
    chk(settle == 0, "R7 no settle", settle, 0);

    // R8: hardware standby from run, exit via reset
    hstby_pin_n = 0; tick(4);
    chk(hw_stby && !osc_en && !clk_en && !bus_oe, "R8 hw standby",
        {hw_stby, osc_en, clk_en, bus_oe}, 8);
    hstby_pin_n = 1;
    wait_exc(code, settle, got);
    chk(got && code == 0, "R8 exit reset code", code, 0);
    chk(!hw_stby, "R8 left hw standby", hw_stby, 0);

    // R4/R5/R6/R10: random wake configurations
    for (int it = 0; it < 30; it++) begin
      int n;
      n = $urandom_range(0, 7);
      enter($urandom_range(0, 1), n);
      irq_en = 8'($urandom); irq_qual = $urandom_range(0, 1);
      cpu_irq_mask = ($urandom_range(0, 3) == 0);
      irq_dma_route = 8'($urandom) & 8'($urandom);
      nmi = ($urandom_range(0, 3) == 0);
      irq = 8'($urandom);
      nmi_in = nmi; irq_in = irq;
      e = exp_code(nmi, irq, irq_en, irq_qual, cpu_irq_mask, irq_dma_route);
      if (e < 0) begin
        tick(20);
        chk(!osc_en && !exc_req, "R4 blocked irq ignored", osc_en, 0);
        nmi_in = 1; e = 1;
      end
      wait_exc(code, settle, got);
      chk(code == e, "R10 wake code", code, e);
      chk(settle == (1 << (SB + n)), "R6 settle length", settle, 1 << (SB + n));
      nmi_in = 0; irq_in = 0; tick(3);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule